// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit rearranges the lanes of a 512-bit vector under a runtime lane mask. It has two directions. In compress, the lanes picked by the mask are gathered into the lowest result slots, in ascending order and without gaps. In expand, the lowest source lanes are taken one after another and placed into the slots picked by the mask, also in ascending order. An element size input selects either sixteen 32-bit lanes or eight 64-bit lanes. Any result slot that receives no element is filled by a fill policy: it is either cleared to zero or taken from the same slot of a merge vector.

The source, merge vector, mask and controls arrive on one cycle, qualified by `in_valid`. The result comes out one cycle later on `out_data`, with `out_valid` high. A two-state controller tracks whether the output register holds a fresh result. In `ST_EMPTY`, `out_valid` is low. In `ST_FULL`, a result captured on the previous edge is presented. The transition `EMPTY->FULL` fires on `in_valid`. `FULL->FULL` is a back-to-back result. `FULL->EMPTY` fires on an idle cycle, and `EMPTY->EMPTY` covers an idle cycle while already empty. Reset forces `ST_EMPTY`.

Top module: `cxu_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle. The result is the function of the inputs sampled at that previous clock edge.
- R3: With `in_mode`=0 (compress), for each set mask bit i taken in ascending order, the k-th such bit places source lane i into result slot k (k counts from 0).
- R4: In compress, result slots at or above the number of set mask bits take the fill value. With `in_zero`=1 the fill value is zero. With `in_zero`=0 it is the merge vector's lane in that slot.
- R5: With `in_mode`=1 (expand), a result slot i whose mask bit is set receives source lane k, where k is the number of set mask bits below i.
- R6: In expand, a result slot whose mask bit is clear takes the fill value defined in R4.
- R7: With `in_wide`=0, lanes are 32 bits wide and `in_mask[15:0]` is used. With `in_wide`=1, lanes are 64 bits wide, only `in_mask[7:0]` is used, and `in_mask[15:8]` has no effect.
- R8: A mask with no used bit set gives exactly the fill vector: all zeros, or the whole merge vector.
- R9: In a cycle after `in_valid` was low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inputs on this cycle form an operation |
| in_mode | input | 1 | 0 = compress, 1 = expand |
| in_wide | input | 1 | 0 = 16 x 32-bit lanes, 1 = 8 x 64-bit lanes |
| in_zero | input | 1 | 1 = unfilled slots zero, 0 = unfilled slots from merge vector |
| in_mask | input | 16 | Lane mask, bit i selects lane i |
| in_src | input | 512 | Source vector, lane 0 in the low bits |
| in_merge | input | 512 | Merge vector for unfilled slots |
| out_valid | output | 1 | Result on `out_data` is fresh |
| out_data | output | 512 | Registered result vector |

## Verification
The bench builds the unit with its default parameters: a 512-bit vector, 32-bit narrow lanes and 64-bit wide lanes. Both lane counts, sixteen and eight, are therefore live in one build, and the prefix-count network of each width is exercised. This makes it possible to drive masks whose upper byte is set while in wide mode and to confirm that those bits change nothing. Directed masks cover these cases:
- all ones
- empty
- single bit
- sparse patterns in both directions under both fill policies

Random operations with interleaved idle cycles cover the rest of the mask space and the hold-versus-update timing of the output register.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

    typedef enum logic {
        CX_COMPRESS = 1'b0,
        CX_EXPAND   = 1'b1
    } cx_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } cx_state_e;

endpackage

// File: rtl/cxu_prefix.sv
// Exclusive prefix population count: rank[i] = number of set bits below i.
module cxu_prefix #(
    parameter int N = 16
) (
    input  logic [N-1:0]          sel,
    output logic [N-1:0][RW-1:0]  rank
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;

    assign rank[0] = '0;

    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign rank[i] = rank[i-1] + RW'(sel[i-1]);
        end
    endgenerate

endmodule

// File: rtl/cxu_path.sv
// One lane-width datapath: compress or expand N lanes of EW bits.
module cxu_path #(
    parameter int EW = 32,
    parameter int N  = 16
) (
    input  logic            op_expand,
    input  logic            fill_zero,
    input  logic [N-1:0]    sel,
    input  logic [N*EW-1:0] src,
    input  logic [N*EW-1:0] mrg,
    output logic [N*EW-1:0] res
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][RW-1:0] rank;
    logic [N-1:0][EW-1:0] src_a;
    logic [N-1:0][EW-1:0] mrg_a;
    logic [N-1:0][EW-1:0] res_a;

    assign src_a = src;
    assign mrg_a = mrg;
    assign res   = res_a;

    cxu_prefix #(.N(N)) u_prefix (
        .sel  (sel),
        .rank (rank)
    );

    always_comb begin
        for (int j = 0; j < N; j++) begin
            res_a[j] = fill_zero ? '0 : mrg_a[j];
        end
        if (op_expand) begin
            for (int i = 0; i < N; i++) begin
                if (sel[i]) res_a[i] = src_a[rank[i]];
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (sel[i]) res_a[rank[i]] = src_a[i];
            end
        end
    end

endmodule

// File: rtl/cxu_unit.sv
module cxu_unit #(
    parameter int VEC_W     = 512,
    parameter int EW_NARROW = 32,
    parameter int EW_WIDE   = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_mode,
    input  logic             in_wide,
    input  logic             in_zero,
    input  logic [15:0]      in_mask,
    input  logic [VEC_W-1:0] in_src,
    input  logic [VEC_W-1:0] in_merge,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    import cxu_pkg::*;

    localparam int N_NARROW = VEC_W / EW_NARROW;
    localparam int N_WIDE   = VEC_W / EW_WIDE;

    cx_state_e        state_q, state_d;
    logic [VEC_W-1:0] narrow_res;
    logic [VEC_W-1:0] wide_res;
    logic [VEC_W-1:0] next_res;
    logic             is_expand;

    assign is_expand = (in_mode == CX_EXPAND);

    cxu_path #(.EW(EW_NARROW), .N(N_NARROW)) u_narrow (
        .op_expand (is_expand),
        .fill_zero (in_zero),
        .sel       (in_mask[N_NARROW-1:0]),
        .src       (in_src),
        .mrg       (in_merge),
        .res       (narrow_res)
    );

    cxu_path #(.EW(EW_WIDE), .N(N_WIDE)) u_wide (
        .op_expand (is_expand),
        .fill_zero (in_zero),
        .sel       (in_mask[N_WIDE-1:0]),
        .src       (in_src),
        .mrg       (in_merge),
        .res       (wide_res)
    );

    assign next_res = in_wide ? wide_res : narrow_res;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= next_res;
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/cxu_unit_chk.sv
module cxu_unit_chk #(
    parameter int VEC_W     = 512,
    parameter int EW_NARROW = 32,
    parameter int EW_WIDE   = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_mode,
    input logic             in_wide,
    input logic             in_zero,
    input logic [15:0]      in_mask,
    input logic [VEC_W-1:0] in_src,
    input logic [VEC_W-1:0] in_merge,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data
);
    localparam int N_NARROW = VEC_W / EW_NARROW;
    localparam int N_WIDE   = VEC_W / EW_WIDE;

    logic no_sel;
    assign no_sel = in_wide ? (in_mask[N_WIDE-1:0] == '0)
                            : (in_mask[N_NARROW-1:0] == '0);

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (!out_valid && out_data == '0);
        end
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_compress_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && !in_wide && in_mask[0])
        |=> out_data[EW_NARROW-1:0] == $past(in_src[EW_NARROW-1:0]));

    p_compress_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && !in_wide && in_zero && !(&in_mask[N_NARROW-1:0]))
        |=> out_data[VEC_W-1 -: EW_NARROW] == '0);

    p_expand_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && !in_wide && in_mask[0])
        |=> out_data[EW_NARROW-1:0] == $past(in_src[EW_NARROW-1:0]));

    p_expand_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && !in_wide && in_zero && !in_mask[N_NARROW-1])
        |=> out_data[VEC_W-1 -: EW_NARROW] == '0);

    p_wide_upper_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_wide && in_zero && in_mask[N_WIDE-1:0] == 1)
        |=> out_data[VEC_W-1:EW_WIDE] == '0);

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero && no_sel) |=> out_data == '0);

    p_empty_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero && no_sel) |=> out_data == $past(in_merge));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

endmodule

bind cxu_unit cxu_unit_chk #(
    .VEC_W     (VEC_W),
    .EW_NARROW (EW_NARROW),
    .EW_WIDE   (EW_WIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_wide   (in_wide),
    .in_zero   (in_zero),
    .in_mask   (in_mask),
    .in_src    (in_src),
    .in_merge  (in_merge),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cxu_unit_test.sv
`timescale 1ns/1ps
module cxu_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_mode = 1'b0;
    logic         in_wide = 1'b0;
    logic         in_zero = 1'b0;
    logic [15:0]  in_mask = '0;
    logic [511:0] in_src = '0;
    logic [511:0] in_merge = '0;
    logic         out_valid;
    logic [511:0] out_data;

    always #10 clk = ~clk;

    cxu_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_wide   (in_wide),
        .in_zero   (in_zero),
        .in_mask   (in_mask),
        .in_src    (in_src),
        .in_merge  (in_merge),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int           checks = 0;
    int           fails = 0;
    bit           done = 0;
    logic         exp_valid = 1'b0;
    logic [511:0] exp_data = '0;
    string        exp_tag = "R1";

    function automatic logic [511:0] rnd512();
        logic [511:0] v = '0;
        for (int k = 0; k < 16; k++) v = (v << 32) | 512'($urandom);
        return v;
    endfunction

    function automatic logic [63:0] lane_get(logic [511:0] v, int idx, int ew);
        logic [511:0] t = v >> (idx * ew);
        return (ew == 64) ? t[63:0] : {32'h0, t[31:0]};
    endfunction

    // Behavioural reference: a queue of picked or consumed lanes.
    function automatic logic [511:0] ref_model(logic op, logic wide, logic zro,
                                               logic [15:0] m,
                                               logic [511:0] s, logic [511:0] mg);
        int           ew = wide ? 64 : 32;
        int           n  = 512 / ew;
        logic [63:0]  q[$];
        logic [511:0] r = '0;
        int           k = 0;
        logic [63:0]  val;
        if (!op) begin
            for (int i = 0; i < n; i++) if (m[i]) q.push_back(lane_get(s, i, ew));
            for (int j = 0; j < n; j++) begin
                if (j < q.size()) val = q[j];
                else              val = zro ? 64'h0 : lane_get(mg, j, ew);
                r = r | (512'(val) << (j * ew));
            end
        end else begin
            for (int i = 0; i < n; i++) q.push_back(lane_get(s, i, ew));
            for (int i = 0; i < n; i++) begin
                if (m[i]) begin
                    val = q[k];
                    k++;
                end else begin
                    val = zro ? 64'h0 : lane_get(mg, i, ew);
                end
                r = r | (512'(val) << (i * ew));
            end
        end
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            fails++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     exp_tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    task automatic step(logic v, logic op, logic wide, logic zro, logic [15:0] m,
                        logic [511:0] s, logic [511:0] mg, string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        in_mode  = op;
        in_wide  = wide;
        in_zero  = zro;
        in_mask  = m;
        in_src   = s;
        in_merge = mg;
        exp_valid = v;
        if (v) exp_data = ref_model(op, wide, zro, m, s, mg);
        exp_tag = tag;
    endtask

    initial begin
        logic [511:0] sa;
        logic [511:0] mb;
        sa = rnd512();
        mb = rnd512();
        // R1: reset state
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R3 compress, zero fill, sparse and full masks
        step(1, 0, 0, 1, 16'hA5A5, sa, mb, "R3");
        step(1, 0, 0, 1, 16'hFFFF, sa, mb, "R3");
        // R4 compress, merge fill above the count
        step(1, 0, 0, 0, 16'h0007, sa, mb, "R4");
        step(1, 0, 0, 0, 16'h8000, sa, mb, "R4");
        // R5 expand zero fill; R6 expand merge fill
        step(1, 1, 0, 1, 16'h8421, sa, mb, "R5");
        step(1, 1, 0, 1, 16'hFFFF, sa, mb, "R5");
        step(1, 1, 0, 0, 16'h00F0, sa, mb, "R6");
        // R7 wide lanes, upper mask byte must not matter
        step(1, 0, 1, 1, 16'hFF35, sa, mb, "R7");
        step(1, 1, 1, 0, 16'hAA81, sa, mb, "R7");
        step(1, 0, 1, 0, 16'h5A80, sa, mb, "R7");
        // R8 empty masks
        step(1, 0, 0, 1, 16'h0000, sa, mb, "R8");
        step(1, 1, 0, 0, 16'h0000, sa, mb, "R8");
        step(1, 1, 1, 1, 16'hFF00, sa, mb, "R8");
        // R9 idle cycles with changing inputs hold the result
        step(1, 1, 0, 0, 16'h1234, sa, mb, "R5");
        step(0, 0, 1, 1, 16'hFFFF, rnd512(), rnd512(), "R9");
        step(0, 1, 0, 0, 16'h0001, rnd512(), rnd512(), "R9");
        // R2 random stream with interleaved idle cycles
        for (int t = 0; t < 400; t++) begin
            step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), rnd512(), rnd512(), "R2");
        end
        step(0, 0, 0, 0, 16'h0, '0, '0, "R9");
        step(0, 0, 0, 0, 16'h0, '0, '0, "R9");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule